// File: doc/BRIEF.md
# Bus Transceiver Mode Controller

This block is the digital control section of a two-wire differential bus transceiver. A host selects one of five operating modes. The block gates the transmitter from the mode, from a transmit request made by the protocol controller, and from an independent guardian enable. It turns the digitised receive state into a received-data bit through a set/reset latch. It watches a local wake pin and the bus for wake-up requests so that the transceiver can leave sleep, and it reports diagnostics through a registered status word.

All outputs are registered. Reset is synchronous and active high, and it leaves the block in standby. Mode commands arrive as a one-cycle strobe with a 3-bit code. The host reads the status word in the cycle where it raises `host_rd`. The sticky bits are cleared at that edge, unless a new event sets them at the same edge.

Top module: `bxcvr_mode_ctrl`

## Requirements
- R1: Mode codes are normal=0, receive-only=1, standby=2, power-on standby=3 and sleep=4, and `status[2:0]` shows the current mode. A strobed command with one of these codes takes effect at the next clock edge, provided the block is not in sleep.
- R2: A command with code 5, 6 or 7 leaves the mode unchanged and sets `status[3]`. The bit stays set until an edge where `host_rd` is high.
- R3: The transmitter is driven only in normal mode. `drv_en` and `drv_data` are high after an edge only when the mode held before that edge was normal, and `drv_data` equals `tx_data` while `drv_en` is high. In receive-only mode `drv_en` stays low, but `rx_data` still follows the bus.
- R4: When `guard_en` is low before an edge, `drv_en` is low after that edge, whatever `tx_en` does. If the block is in normal mode with `tx_en` high while `guard_en` is low, `status[6]` is set and held until it is read.
- R5: In sleep, every host command is ignored. The block leaves sleep, and always goes to standby, only when a local or remote wake event occurs.
- R6: A local wake event is the `PIN_LEN`-th consecutive cycle (default 4) in which `wake_pin` is high. Shorter pulses cause no event.
- R7: A remote wake event is the `REM_LEN`-th consecutive cycle (default 8) in which `bus_state` is Data_0. A shorter run of Data_0 causes no event.
- R8: A wake event that takes the block out of sleep sets `status[4]` if it was local, `status[5]` if it was remote, or both if both occurred. `wake_flag` is high while either bit is set. `host_rd` clears both bits at the next edge, but a new event at that same edge wins.
- R9: Bus encoding is 00 idle, 01 Data_0, 10 Data_1, 11 idle. The latch sets on Data_1, resets on Data_0 and holds otherwise. `rx_data` shows the latch in normal and receive-only modes and shows 1 in every other mode.
- R10: After any change of mode, `drv_en` stays low for one more cycle beyond the usual registered latency.
- R11: After reset the block is in standby, with `drv_en`=0, `drv_data`=0, `rx_data`=1, `wake_flag`=0 and `status`=8'h02.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | Mode command strobe |
| cmd_code | input | 3 | Requested mode code |
| host_rd | input | 1 | Status read strobe; clears the sticky bits |
| tx_data | input | 1 | Transmit bit from the protocol controller |
| tx_en | input | 1 | Transmit request from the protocol controller |
| guard_en | input | 1 | Guardian permission to drive the bus |
| wake_pin | input | 1 | Local wake input |
| bus_state | input | 2 | Digitised bus state |
| drv_en | output | 1 | Transmitter enable |
| drv_data | output | 1 | Transmitter data |
| rx_data | output | 1 | Received data |
| wake_flag | output | 1 | A wake source is recorded |
| status | output | 8 | {0, guard block, remote wake, local wake, code error, mode[2:0]} |

## Verification
The bench exercises several boundary cases:

- It sends a wake pulse one cycle short of the threshold, both on the pin and as a Data_0 run on the bus. A filter that is off by one would wake the block early.
- It sends commands while the block is asleep. A design that honours them would leave sleep without any wake event.
- It sends unused codes. A careless decoder would load them into the mode field.
- It raises a read strobe at the same edge as a new wake event. A design where the clear wins would lose that wake source.
- It switches modes while a transmit request is held. A design without the hold-off would drive the bus one cycle too early.
- It drops the guardian enable during a transmission. A design that ignores the guardian would keep driving the bus.

// File: rtl/bxc_pkg.sv
`timescale 1ns/1ps
package bxc_pkg;
  typedef enum logic [2:0] {
    MD_NORMAL  = 3'd0,
    MD_RXONLY  = 3'd1,
    MD_STANDBY = 3'd2,
    MD_PWRSTBY = 3'd3,
    MD_SLEEP   = 3'd4
  } mode_e;

  localparam logic [1:0] BUS_IDLE = 2'b00;
  localparam logic [1:0] BUS_D0   = 2'b01;
  localparam logic [1:0] BUS_D1   = 2'b10;
endpackage

// File: rtl/bxc_run_filter.sv
`timescale 1ns/1ps
module bxc_run_filter #(
  parameter int LEN = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic level,
  output logic evt
);
  localparam int CW = $clog2(LEN + 1);
  localparam logic [CW-1:0] LAST = CW'(LEN - 1);
  localparam logic [CW-1:0] TOP  = CW'(LEN);

  logic [CW-1:0] run_q;

  assign evt = level && (run_q == LAST);

  always_ff @(posedge clk) begin
    if (rst)              run_q <= '0;
    else if (!level)      run_q <= '0;
    else if (run_q != TOP) run_q <= run_q + 1'b1;
  end

  AST_EVT_SINGLE: assert property (@(posedge clk) disable iff (rst)
    evt |=> !evt); // R6
  AST_EVT_NEEDS_LEVEL: assert property (@(posedge clk) disable iff (rst)
    !level |=> !evt); // R7
endmodule

// File: rtl/bxc_rx_latch.sv
`timescale 1ns/1ps
module bxc_rx_latch
  import bxc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] bus_state,
  input  logic       pass_en,
  output logic       rx_o
);
  logic lat_q, lat_d, rx_q;

  always_comb begin
    lat_d = lat_q;
    if (bus_state == BUS_D1)      lat_d = 1'b1;
    else if (bus_state == BUS_D0) lat_d = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lat_q <= 1'b1;
      rx_q  <= 1'b1;
    end else begin
      lat_q <= lat_d;
      rx_q  <= pass_en ? lat_d : 1'b1;
    end
  end

  assign rx_o = rx_q;

  AST_RX_SET: assert property (@(posedge clk) disable iff (rst)
    (pass_en && bus_state == BUS_D1) |=> rx_o); // R9
  AST_RX_RESET: assert property (@(posedge clk) disable iff (rst)
    (pass_en && bus_state == BUS_D0) |=> !rx_o); // R9
  AST_RX_QUIET: assert property (@(posedge clk) disable iff (rst)
    !pass_en |=> rx_o); // R9
endmodule

// File: rtl/bxc_mode_fsm.sv
`timescale 1ns/1ps
module bxc_mode_fsm
  import bxc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       cmd_valid,
  input  logic [2:0] cmd_code,
  input  logic       host_rd,
  input  logic       loc_evt,
  input  logic       rem_evt,
  input  logic       tx_en,
  input  logic       guard_en,
  output mode_e      mode_q,
  output logic       chg_q,
  output logic       err_q,
  output logic       wk_loc_q,
  output logic       wk_rem_q,
  output logic       gblk_q
);
  mode_e mode_d;
  logic  bad_code, in_sleep, woke, gblk_set;

  assign in_sleep = (mode_q == MD_SLEEP);
  assign woke     = in_sleep && (loc_evt || rem_evt);
  assign bad_code = cmd_valid && !in_sleep && (cmd_code > 3'(MD_SLEEP));
  assign gblk_set = (mode_q == MD_NORMAL) && tx_en && !guard_en;

  always_comb begin
    mode_d = mode_q;
    if (woke)
      mode_d = MD_STANDBY;
    else if (cmd_valid && !in_sleep && !bad_code)
      mode_d = mode_e'(cmd_code);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q   <= MD_STANDBY;
      chg_q    <= 1'b0;
      err_q    <= 1'b0;
      wk_loc_q <= 1'b0;
      wk_rem_q <= 1'b0;
      gblk_q   <= 1'b0;
    end else begin
      mode_q <= mode_d;
      chg_q  <= (mode_d != mode_q);
      if (bad_code)               err_q <= 1'b1;
      else if (host_rd)           err_q <= 1'b0;
      if (woke && loc_evt)        wk_loc_q <= 1'b1;
      else if (host_rd)           wk_loc_q <= 1'b0;
      if (woke && rem_evt)        wk_rem_q <= 1'b1;
      else if (host_rd)           wk_rem_q <= 1'b0;
      if (gblk_set)               gblk_q <= 1'b1;
      else if (host_rd)           gblk_q <= 1'b0;
    end
  end

  AST_SLEEP_HOLD: assert property (@(posedge clk) disable iff (rst)
    (in_sleep && !loc_evt && !rem_evt) |=> (mode_q == MD_SLEEP)); // R5
  AST_WAKE_TO_STANDBY: assert property (@(posedge clk) disable iff (rst)
    woke |=> (mode_q == MD_STANDBY) && (wk_loc_q || wk_rem_q)); // R8
  AST_BAD_CODE_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !in_sleep && cmd_code > 3'd4) |=> ($stable(mode_q) && err_q)); // R2
  AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (rst)
    mode_q <= MD_SLEEP); // R1
endmodule

// File: rtl/bxcvr_mode_ctrl.sv
`timescale 1ns/1ps
module bxcvr_mode_ctrl
  import bxc_pkg::*;
#(
  parameter int PIN_LEN = 4,
  parameter int REM_LEN = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cmd_valid,
  input  logic [2:0] cmd_code,
  input  logic       host_rd,
  input  logic       tx_data,
  input  logic       tx_en,
  input  logic       guard_en,
  input  logic       wake_pin,
  input  logic [1:0] bus_state,
  output logic       drv_en,
  output logic       drv_data,
  output logic       rx_data,
  output logic       wake_flag,
  output logic [7:0] status
);
  mode_e mode_q;
  logic  chg_q, err_q, wk_loc_q, wk_rem_q, gblk_q;
  logic  loc_evt, rem_evt, pass_en, drv_d;
  logic  drv_en_q, drv_data_q;

  bxc_run_filter #(.LEN(PIN_LEN)) u_pin_flt (
    .clk(clk), .rst(rst), .level(wake_pin), .evt(loc_evt));

  bxc_run_filter #(.LEN(REM_LEN)) u_bus_flt (
    .clk(clk), .rst(rst), .level(bus_state == BUS_D0), .evt(rem_evt));

  bxc_mode_fsm u_fsm (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .host_rd(host_rd), .loc_evt(loc_evt), .rem_evt(rem_evt),
    .tx_en(tx_en), .guard_en(guard_en), .mode_q(mode_q), .chg_q(chg_q),
    .err_q(err_q), .wk_loc_q(wk_loc_q), .wk_rem_q(wk_rem_q), .gblk_q(gblk_q));

  assign pass_en = (mode_q == MD_NORMAL) || (mode_q == MD_RXONLY);

  bxc_rx_latch u_rx (
    .clk(clk), .rst(rst), .bus_state(bus_state), .pass_en(pass_en), .rx_o(rx_data));

  assign drv_d = (mode_q == MD_NORMAL) && !chg_q && tx_en && guard_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      drv_en_q   <= 1'b0;
      drv_data_q <= 1'b0;
    end else begin
      drv_en_q   <= drv_d;
      drv_data_q <= drv_d && tx_data;
    end
  end

  assign drv_en    = drv_en_q;
  assign drv_data  = drv_data_q;
  assign wake_flag = wk_loc_q || wk_rem_q;
  assign status    = {1'b0, gblk_q, wk_rem_q, wk_loc_q, err_q, mode_q};

  AST_NO_TX_OUTSIDE_NORMAL: assert property (@(posedge clk) disable iff (rst)
    (mode_q != MD_NORMAL) |=> !drv_en); // R3
  AST_GUARD_BLOCK: assert property (@(posedge clk) disable iff (rst)
    !guard_en |=> !drv_en); // R4
  AST_HOLDOFF: assert property (@(posedge clk) disable iff (rst)
    (mode_q != $past(mode_q)) |=> !drv_en); // R10
  AST_DATA_GATED: assert property (@(posedge clk) disable iff (rst)
    drv_data |-> drv_en); // R3
endmodule

// File: tb/bxcvr_mode_ctrl_bench.sv
`timescale 1ns/1ps
module bxcvr_mode_ctrl_bench;
  localparam int PIN = 4;
  localparam int REM = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_valid = 1'b0;
  logic [2:0] cmd_code = 3'd0;
  logic host_rd = 1'b0, tx_data = 1'b0, tx_en = 1'b0, guard_en = 1'b1, wake_pin = 1'b0;
  logic [1:0] bus_state = 2'b00;
  logic drv_en, drv_data, rx_data, wake_flag;
  logic [7:0] status;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  bxcvr_mode_ctrl #(.PIN_LEN(PIN), .REM_LEN(REM)) u_bxcvr_mode_ctrl (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .host_rd(host_rd), .tx_data(tx_data), .tx_en(tx_en), .guard_en(guard_en),
    .wake_pin(wake_pin), .bus_state(bus_state), .drv_en(drv_en),
    .drv_data(drv_data), .rx_data(rx_data), .wake_flag(wake_flag), .status(status));

  // behavioural reference state
  int m_mode, m_pc, m_rc;
  bit m_chg, m_err, m_wl, m_wr, m_gb, m_drv, m_dd, m_lat, m_rx;

  always @(posedge clk) begin
    if (rst) begin
      m_mode = 2; m_chg = 0; m_err = 0; m_wl = 0; m_wr = 0; m_gb = 0;
      m_drv = 0; m_dd = 0; m_lat = 1; m_rx = 1; m_pc = 0; m_rc = 0;
    end else begin
      bit loc, rem, nlat;
      int nm;
      loc = wake_pin && (m_pc == PIN - 1);
      rem = (bus_state == 2'b01) && (m_rc == REM - 1);
      nlat = (bus_state == 2'b10) ? 1'b1 : (bus_state == 2'b01) ? 1'b0 : m_lat;
      m_drv = (m_mode == 0) && !m_chg && tx_en && guard_en;
      m_dd  = m_drv && tx_data;
      m_rx  = (m_mode == 0 || m_mode == 1) ? nlat : 1'b1;
      m_lat = nlat;
      if (m_mode == 0 && tx_en && !guard_en) m_gb = 1; else if (host_rd) m_gb = 0;
      nm = m_mode;
      if (m_mode == 4 && (loc || rem)) begin
        nm = 2;
        if (loc) m_wl = 1; else if (host_rd) m_wl = 0;
        if (rem) m_wr = 1; else if (host_rd) m_wr = 0;
        if (host_rd) m_err = 0;
      end else begin
        if (host_rd) begin m_wl = 0; m_wr = 0; end
        if (m_mode != 4 && cmd_valid && cmd_code > 3'd4) m_err = 1;
        else if (host_rd) m_err = 0;
        if (m_mode != 4 && cmd_valid && cmd_code <= 3'd4) nm = int'(cmd_code);
      end
      m_chg = (nm != m_mode);
      m_mode = nm;
      m_pc = !wake_pin ? 0 : (m_pc < PIN ? m_pc + 1 : m_pc);
      m_rc = (bus_state != 2'b01) ? 0 : (m_rc < REM ? m_rc + 1 : m_rc);
    end
  end

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s at %0t: actual=%0d expected=%0d", tag, $time, act, exp);
    end
  endtask

  task automatic compare_all();
    chk("R1 R5 mode", int'(status[2:0]), m_mode);
    chk("R2 code error", int'(status[3]), int'(m_err));
    chk("R3 R4 R10 drv_en", int'(drv_en), int'(m_drv));
    chk("R3 drv_data", int'(drv_data), int'(m_dd));
    chk("R9 rx_data", int'(rx_data), int'(m_rx));
    chk("R6 R8 local source", int'(status[4]), int'(m_wl));
    chk("R7 R8 remote source", int'(status[5]), int'(m_wr));
    chk("R4 guard diag", int'(status[6]), int'(m_gb));
    chk("R8 wake_flag", int'(wake_flag), int'(m_wl || m_wr));
    chk("R1 status top bit", int'(status[7]), 0);
  endtask

  task automatic tick();
    @(negedge clk);
    compare_all();
  endtask

  task automatic cmd(input logic [2:0] c);
    cmd_valid = 1'b1; cmd_code = c;
    tick();
    cmd_valid = 1'b0;
  endtask

  task automatic rd();
    host_rd = 1'b1;
    tick();
    host_rd = 1'b0;
  endtask

  initial begin
    #(5.0 * 20000);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    tick(); tick(); tick();
    rst = 1'b0;
    // R11 reset state
    chk("R11 status", int'(status), 8'h02);
    chk("R11 drv_en", int'(drv_en), 0);
    chk("R11 rx_data", int'(rx_data), 1);
    chk("R11 wake_flag", int'(wake_flag), 0);
    tick();

    // normal mode with traffic, hold-off on entry (R10)
    tx_en = 1'b1;
    cmd(3'd0);
    chk("R1 enters normal", int'(status[2:0]), 0);
    for (int i = 0; i < 12; i++) begin
      tx_data = i[0];
      bus_state = (i % 4 == 0) ? 2'b10 : (i % 4 == 1) ? 2'b00 : (i % 4 == 2) ? 2'b01 : 2'b11;
      tick();
    end
    chk("R10 drive after hold-off", int'(drv_en), 1);

    // guardian blocks transmission (R4)
    guard_en = 1'b0;
    tick(); tick();
    chk("R4 guard blocks", int'(drv_en), 0);
    chk("R4 guard diag set", int'(status[6]), 1);
    guard_en = 1'b1;
    tick();
    rd();
    tick();
    chk("R4 diag cleared", int'(status[6]), 0);

    // receive-only (R3)
    cmd(3'd1);
    for (int i = 0; i < 6; i++) begin
      bus_state = i[0] ? 2'b01 : 2'b10;
      tx_data = ~tx_data;
      tick();
    end
    chk("R3 no drive in rx-only", int'(drv_en), 0);

    // unused codes (R2)
    cmd(3'd6);
    chk("R2 mode kept", int'(status[2:0]), 1);
    chk("R2 error set", int'(status[3]), 1);
    cmd(3'd7);
    rd();
    chk("R2 error cleared", int'(status[3]), 0);
    cmd(3'd1);
    tick();

    // sleep, ignored commands, short pin pulse, then local wake (R5 R6)
    bus_state = 2'b00;
    cmd(3'd4);
    cmd(3'd0);
    cmd(3'd6);
    chk("R5 sleep holds", int'(status[2:0]), 4);
    chk("R5 no error in sleep", int'(status[3]), 0);
    chk("R9 rx quiet in sleep", int'(rx_data), 1);
    wake_pin = 1'b1;
    tick(); tick(); tick();
    wake_pin = 1'b0;
    tick();
    chk("R6 short pulse ignored", int'(status[2:0]), 4);
    wake_pin = 1'b1;
    for (int i = 0; i < 4; i++) tick();
    chk("R6 woken to standby", int'(status[2:0]), 2);
    chk("R8 local recorded", int'(status[4]), 1);
    wake_pin = 1'b0;
    tick();
    rd();
    chk("R8 cleared on read", int'(wake_flag), 0);

    // remote wake (R7)
    cmd(3'd4);
    bus_state = 2'b01;
    for (int i = 0; i < 7; i++) tick();
    bus_state = 2'b00;
    tick();
    chk("R7 short run ignored", int'(status[2:0]), 4);
    bus_state = 2'b01;
    for (int i = 0; i < 9; i++) tick();
    chk("R7 remote recorded", int'(status[5]), 1);
    chk("R7 left sleep", int'(status[2:0]), 2);
    bus_state = 2'b00;
    rd();

    // power-on standby then normal again
    cmd(3'd3);
    tick();
    cmd(3'd0);
    for (int i = 0; i < 4; i++) begin tx_data = i[1]; tick(); end

    // read at the same edge as a wake event: set wins (R8)
    cmd(3'd4);
    wake_pin = 1'b1;
    tick(); tick(); tick();
    host_rd = 1'b1;
    tick();
    host_rd = 1'b0;
    chk("R8 set beats clear", int'(status[4]), 1);
    wake_pin = 1'b0;
    tick(); tick();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule